// File: doc/BRIEF.md
# Two-Thread Decode Slot Arbiter

This block picks, every clock cycle, which of the two hardware threads of a simultaneously multithreaded core may use the single decode slot. Software gives each thread a 3-bit level. The level sets the thread's weight in a credit scheme that repeats over a fixed 16-cycle window. Cycles that the credits leave unclaimed go to whichever thread is still able to decode.

The weights are corrected at run time from two counts that the rest of the core supplies for each thread. The first is the number of occupied completion-table entries; each entry holds a group of up to five instructions. The second is the number of L2 misses still outstanding. A thread over either limit has its weight halved for the next window.

A thread that raises its sync-pending flag receives a one-cycle flush pulse for the instructions waiting at dispatch. It also gets a fetch-hold level that lasts as long as the sync, and it loses the slot while the sync is pending. When both threads sit at level 1, the block enters a low-power mode that allows a grant only once every eight cycles.

Top module: `smt_decode_arb`

## Requirements
- R1: A thread whose level input is 0 never receives a grant. When one thread is at level 0 and the other is eligible, the other thread takes all 16 slots of the window.
- R2: `grant_o` (bit 0 = thread 0, bit 1 = thread 1) has at most one bit set. It is registered, so it reflects the inputs of the previous clock cycle.
- R3: Consider two eligible threads, not in low-power mode, with effective weights e0 and e1. In each 16-cycle window, thread 0 receives e0 + ceil(L/2) grants when e0 >= e1, and e0 + floor(L/2) grants otherwise, where L = 16 - e0 - e1. Thread 1 receives the remaining slots.
- R4: Slots that the credits leave unused go to the other eligible thread. A single eligible thread is granted in every cycle of the window.
- R5: When both level inputs equal 1, `throttle_o` is 1 from the next cycle on. At most one grant is issued in any eight consecutive cycles, and each thread gets exactly one grant per 16-cycle window.
- R6: A completion-table count above OCC_TH halves the thread's weight, with a floor of 1. The new weight applies from the next window. A count equal to OCC_TH has no effect.
- R7: An outstanding-miss count above MISS_TH halves the weight in the same way. A count equal to MISS_TH has no effect.
- R8: When a sync-pending input rises, `flush_o` for that thread is 1 for exactly one cycle, starting one cycle after the rise. `fetch_hold_o` for that thread follows the input with a one-cycle delay. A thread under fetch hold receives no grant.
- R9: During reset, `grant_o`, `flush_o`, `fetch_hold_o` and `throttle_o` are all 0.
- R10: When neither thread is eligible (level 0 or sync pending), `grant_o` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lvl_t0_i | input | 3 | Software level for thread 0 (0 = idle) |
| lvl_t1_i | input | 3 | Software level for thread 1 (0 = idle) |
| occ_t0_i | input | OCC_W | Completion-table entries held by thread 0 |
| occ_t1_i | input | OCC_W | Completion-table entries held by thread 1 |
| miss_t0_i | input | MISS_W | Outstanding L2 misses of thread 0 |
| miss_t1_i | input | MISS_W | Outstanding L2 misses of thread 1 |
| sync_t0_i | input | 1 | Thread 0 has a sync in progress |
| sync_t1_i | input | 1 | Thread 1 has a sync in progress |
| grant_o | output | 2 | One-hot decode grant, or zero |
| flush_o | output | 2 | One-cycle dispatch flush pulse per thread |
| fetch_hold_o | output | 2 | Fetch inhibit per thread while a sync is pending |
| throttle_o | output | 1 | Low-power decode mode active |

## Verification
A wrong credit count or window counter does not show up in any single cycle. It shows up as a per-thread grant count over 16 cycles that differs from the closed-form share. The bench therefore sweeps all 64 level pairs and compares whole-window totals, which exposes such a fault within one window after the inputs settle. A wrong eligibility or hold state shows up within one cycle: a grant appears for an idle or syncing thread, or the flush pulse has the wrong length. The threshold edges are probed at exactly the limit and at one above it, so an off-by-one comparison shifts the shares by a visible number of slots.

// File: rtl/smt_arb_pkg.sv
package smt_arb_pkg;
    localparam int NTHR   = 2;
    localparam int LVL_W  = 3;
    typedef logic [LVL_W-1:0] lvl_t;
    typedef logic [NTHR-1:0]  thr_vec_t;
endpackage

// File: rtl/smt_weight_calc.sv
module smt_weight_calc
    import smt_arb_pkg::*;
#(
    parameter int OCC_W   = 5,
    parameter int MISS_W  = 4,
    parameter int OCC_TH  = 12,
    parameter int MISS_TH = 6
) (
    input  lvl_t              lvl_i,
    input  logic [OCC_W-1:0]  occ_i,
    input  logic [MISS_W-1:0] miss_i,
    input  logic              sync_i,
    output lvl_t              eff_w_o,
    output logic              elig_o,
    output logic              floor_o
);
    logic penal;
    lvl_t halved;

    always_comb begin
        // over-limit test is strict: equal to the limit is not a penalty
        penal  = (occ_i > OCC_W'(OCC_TH)) || (miss_i > MISS_W'(MISS_TH));
        halved = lvl_i >> 1;
        if (lvl_i == '0) begin
            eff_w_o = '0;
        end else if (penal) begin
            eff_w_o = (halved == '0) ? lvl_t'(1) : halved;
        end else begin
            eff_w_o = lvl_i;
        end
        elig_o  = (lvl_i != '0) && !sync_i;
        floor_o = (lvl_i == lvl_t'(1));
    end
endmodule

// File: rtl/smt_sync_ctl.sv
module smt_sync_ctl
    import smt_arb_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  thr_vec_t sync_i,
    output thr_vec_t flush_o,
    output thr_vec_t hold_o
);
    typedef struct packed {
        thr_vec_t hold;
        thr_vec_t flush;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.hold  = sync_i;
        st_d.flush = sync_i & ~st_q.hold;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flush_o = st_q.flush;
    assign hold_o  = st_q.hold;

    // R8
    flush_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_o != '0) |=> ((flush_o & $past(flush_o)) == '0));

    // R8
    flush_with_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_o & ~hold_o) == '0);
endmodule

// File: rtl/smt_credit_sel.sv
module smt_credit_sel
    import smt_arb_pkg::*;
#(
    parameter int WIN_LEN    = 16,
    parameter int THR_PERIOD = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  lvl_t [NTHR-1:0]      eff_w_i,
    input  thr_vec_t             elig_i,
    input  logic                 throttle_i,
    output thr_vec_t             grant_o
);
    localparam int WC_W = $clog2(WIN_LEN);
    localparam int TP_W = $clog2(THR_PERIOD);

    typedef struct packed {
        logic [WC_W-1:0]  wcnt;
        lvl_t [NTHR-1:0]  cred;
        logic             rr;
        thr_vec_t         grant;
    } cs_st_t;

    cs_st_t st_d, st_q;

    lvl_t [NTHR-1:0] cur_cred;
    thr_vec_t        has_cred;
    logic            win_start;
    logic            rr_cur;
    logic            slot_ok;
    logic            go;
    logic            sel;
    logic            spill;

    always_comb begin
        st_d      = st_q;
        win_start = (st_q.wcnt == '0);
        for (int t = 0; t < NTHR; t++) begin
            cur_cred[t] = win_start ? eff_w_i[t] : st_q.cred[t];
            has_cred[t] = elig_i[t] && (cur_cred[t] != '0);
        end
        rr_cur  = win_start ? (eff_w_i[1] > eff_w_i[0]) : st_q.rr;
        slot_ok = !throttle_i || (st_q.wcnt[TP_W-1:0] == '0);

        go    = 1'b0;
        sel   = 1'b0;
        spill = 1'b0;
        if (slot_ok) begin
            if (has_cred[0] && has_cred[1]) begin
                go  = 1'b1;
                sel = (cur_cred[1] > cur_cred[0]);
            end else if (has_cred[0]) begin
                go  = 1'b1;
                sel = 1'b0;
            end else if (has_cred[1]) begin
                go  = 1'b1;
                sel = 1'b1;
            end else if (elig_i[0] && elig_i[1]) begin
                go    = 1'b1;
                sel   = rr_cur;
                spill = 1'b1;
            end else if (elig_i[0]) begin
                go    = 1'b1;
                sel   = 1'b0;
                spill = 1'b1;
            end else if (elig_i[1]) begin
                go    = 1'b1;
                sel   = 1'b1;
                spill = 1'b1;
            end
        end

        st_d.cred  = cur_cred;
        st_d.rr    = rr_cur;
        st_d.grant = '0;
        if (go) begin
            st_d.grant[sel] = 1'b1;
            if (spill) st_d.rr = ~sel;
            else       st_d.cred[sel] = cur_cred[sel] - lvl_t'(1);
        end

        if (st_q.wcnt == WC_W'(WIN_LEN - 1)) st_d.wcnt = '0;
        else                                 st_d.wcnt = st_q.wcnt + WC_W'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign grant_o = st_q.grant;

    // R2
    grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant_o));

    // R10
    grant_elig_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_o & ~$past(elig_i)) == '0);

    // R5
    thr_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((grant_o != '0) && throttle_i && $past(throttle_i)) |=> (grant_o == '0));
endmodule

// File: rtl/smt_decode_arb.sv
module smt_decode_arb
    import smt_arb_pkg::*;
#(
    parameter int OCC_W      = 5,
    parameter int MISS_W     = 4,
    parameter int OCC_TH     = 12,
    parameter int MISS_TH    = 6,
    parameter int WIN_LEN    = 16,
    parameter int THR_PERIOD = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        lvl_t0_i,
    input  logic [2:0]        lvl_t1_i,
    input  logic [OCC_W-1:0]  occ_t0_i,
    input  logic [OCC_W-1:0]  occ_t1_i,
    input  logic [MISS_W-1:0] miss_t0_i,
    input  logic [MISS_W-1:0] miss_t1_i,
    input  logic              sync_t0_i,
    input  logic              sync_t1_i,
    output logic [1:0]        grant_o,
    output logic [1:0]        flush_o,
    output logic [1:0]        fetch_hold_o,
    output logic              throttle_o
);
    typedef struct packed {
        logic throttle;
    } top_st_t;

    top_st_t st_d, st_q;

    lvl_t [NTHR-1:0]               lvl_v;
    logic [NTHR-1:0][OCC_W-1:0]    occ_v;
    logic [NTHR-1:0][MISS_W-1:0]   miss_v;
    thr_vec_t                      sync_v;
    lvl_t [NTHR-1:0]               eff_w;
    thr_vec_t                      elig;
    thr_vec_t                      at_floor;
    logic                          throttle_now;

    assign lvl_v  = {lvl_t1_i, lvl_t0_i};
    assign occ_v  = {occ_t1_i, occ_t0_i};
    assign miss_v = {miss_t1_i, miss_t0_i};
    assign sync_v = {sync_t1_i, sync_t0_i};

    for (genvar t = 0; t < NTHR; t++) begin : g_thr
        smt_weight_calc #(
            .OCC_W  (OCC_W),
            .MISS_W (MISS_W),
            .OCC_TH (OCC_TH),
            .MISS_TH(MISS_TH)
        ) wcalc_i (
            .lvl_i  (lvl_v[t]),
            .occ_i  (occ_v[t]),
            .miss_i (miss_v[t]),
            .sync_i (sync_v[t]),
            .eff_w_o(eff_w[t]),
            .elig_o (elig[t]),
            .floor_o(at_floor[t])
        );
    end

    assign throttle_now = &at_floor;

    always_comb begin
        st_d          = st_q;
        st_d.throttle = throttle_now;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign throttle_o = st_q.throttle;

    smt_credit_sel #(
        .WIN_LEN   (WIN_LEN),
        .THR_PERIOD(THR_PERIOD)
    ) csel_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .eff_w_i   (eff_w),
        .elig_i    (elig),
        .throttle_i(throttle_now),
        .grant_o   (grant_o)
    );

    smt_sync_ctl sync_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .sync_i (sync_v),
        .flush_o(flush_o),
        .hold_o (fetch_hold_o)
    );

    // R1
    idle_t0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(lvl_t0_i) == 3'd0) |-> !grant_o[0]);

    // R1
    idle_t1_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(lvl_t1_i) == 3'd0) |-> !grant_o[1]);

    // R8
    hold_nogrant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_o & fetch_hold_o) == '0);

    // R6
    weight_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eff_w[0] <= lvl_v[0]) && ((lvl_v[0] == '0) || (eff_w[0] != '0)));
endmodule

// File: tb/smt_decode_arb_tb.sv
module smt_decode_arb_tb_top;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] lvl0 = '0, lvl1 = '0;
    logic [4:0] occ0 = '0, occ1 = '0;
    logic [3:0] miss0 = '0, miss1 = '0;
    logic       sync0 = 1'b0, sync1 = 1'b0;
    logic [1:0] grant, flush, hold;
    logic       thr;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    smt_decode_arb dut_i (
        .clk(clk), .rst_n(rst_n),
        .lvl_t0_i(lvl0), .lvl_t1_i(lvl1),
        .occ_t0_i(occ0), .occ_t1_i(occ1),
        .miss_t0_i(miss0), .miss_t1_i(miss1),
        .sync_t0_i(sync0), .sync_t1_i(sync1),
        .grant_o(grant), .flush_o(flush),
        .fetch_hold_o(hold), .throttle_o(thr)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // settle for several windows, then count grants over one 16-cycle span
    task automatic measure(output int g0, output int g1, output int bad);
        g0 = 0; g1 = 0; bad = 0;
        repeat (40) @(negedge clk);
        for (int i = 0; i < 16; i++) begin
            @(negedge clk);
            if (grant[0]) g0++;
            if (grant[1]) g1++;
            if (grant == 2'b11) bad++;
        end
    endtask

    function automatic int effw(input int p, input bit pen);
        if (p == 0) return 0;
        if (!pen) return p;
        return (p / 2 == 0) ? 1 : p / 2;
    endfunction

    function automatic int share0(input int e0, input int e1);
        int l;
        l = 16 - e0 - e1;
        return (e1 > e0) ? e0 + l / 2 : e0 + (l + 1) / 2;
    endfunction

    task automatic pair_chk(input string req, input int p0, input int p1,
                            input bit pen0, input bit pen1);
        int g0, g1, bad, x0, x1;
        lvl0 = 3'(p0); lvl1 = 3'(p1);
        measure(g0, g1, bad);
        if (p0 == 0 && p1 == 0) begin x0 = 0; x1 = 0; end
        else if (p0 == 0) begin x0 = 0; x1 = 16; end
        else if (p1 == 0) begin x0 = 16; x1 = 0; end
        else if (p0 == 1 && p1 == 1) begin x0 = 1; x1 = 1; end
        else begin
            x0 = share0(effw(p0, pen0), effw(p1, pen1));
            x1 = 16 - x0;
        end
        chk(g0 == x0, {req, " t0 share"}, g0, x0);
        chk(g1 == x1, {req, " t1 share"}, g1, x1);
        chk(bad == 0, "R2 one-hot", bad, 0);
    endtask

    initial begin
        int g0, g1, bad;
        repeat (3) @(negedge clk);
        // R9 reset state
        chk(grant == 0 && flush == 0 && hold == 0 && thr == 0, "R9 reset", {grant, flush, hold, thr}, 0);
        rst_n = 1'b1;

        // full sweep of level pairs: R1, R3, R4, R5, R10
        for (int p0 = 0; p0 < 8; p0++) begin
            for (int p1 = 0; p1 < 8; p1++) begin
                if (p0 == 0 && p1 == 0)      pair_chk("R10", p0, p1, 0, 0);
                else if (p0 == 0 || p1 == 0) pair_chk("R1 R4", p0, p1, 0, 0);
                else if (p0 == 1 && p1 == 1) pair_chk("R5", p0, p1, 0, 0);
                else                         pair_chk("R3", p0, p1, 0, 0);
            end
        end

        // R5 throttle output
        lvl0 = 3'd1; lvl1 = 3'd1;
        @(negedge clk); @(negedge clk);
        chk(thr == 1'b1, "R5 throttle on", int'(thr), 1);
        lvl1 = 3'd2;
        @(negedge clk); @(negedge clk);
        chk(thr == 1'b0, "R5 throttle off", int'(thr), 0);

        // R6 occupancy threshold edge
        occ0 = 5'd12; pair_chk("R6 at limit", 6, 6, 0, 0);
        occ0 = 5'd13; pair_chk("R6 over limit", 6, 6, 1, 0);
        occ0 = 5'd0;
        occ1 = 5'd20; pair_chk("R6 floor", 1, 3, 0, 1);
        occ1 = 5'd0;

        // R7 miss threshold edge
        miss1 = 4'd6; pair_chk("R7 at limit", 6, 6, 0, 0);
        miss1 = 4'd7; pair_chk("R7 over limit", 6, 6, 0, 1);
        miss1 = 4'd0;

        // R8 sync flush and hold
        lvl0 = 3'd4; lvl1 = 3'd4;
        repeat (20) @(negedge clk);
        sync0 = 1'b1;
        @(negedge clk);
        chk(flush == 2'b01, "R8 flush pulse", flush, 1);
        chk(hold == 2'b01, "R8 hold set", hold, 1);
        chk(grant[0] == 1'b0, "R8 no grant under hold", grant, 2);
        @(negedge clk);
        chk(flush == 2'b00, "R8 flush one cycle", flush, 0);
        measure(g0, g1, bad);
        chk(g0 == 0, "R8 held thread share", g0, 0);
        chk(g1 == 16, "R4 other thread takes all", g1, 16);
        sync1 = 1'b1;
        measure(g0, g1, bad);
        chk(g0 + g1 == 0, "R10 both syncing", g0 + g1, 0);
        sync0 = 1'b0; sync1 = 1'b0;
        @(negedge clk);
        chk(hold == 2'b00, "R8 hold release", hold, 0);
        chk(flush == 2'b00, "R8 no flush on fall", flush, 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule